// File: doc/BRIEF.md
# Iterative DES Cipher Engine

This block encrypts or decrypts one 64-bit block under a 64-bit key. It has a single Feistel round unit that is reused over sixteen clock cycles. The round keys are derived on the fly: each cycle rotates the two 28-bit key halves that came out of the key selection permutation. Decryption rotates them the other way, so the round keys come out in reverse order without any key storage beyond the halves themselves.

The host drives a 2-bit opcode. The engine looks at the opcode only when it is idle or in the final cycle of a job. The idle flag and the last-cycle flag therefore tell the host when the next block and key can be presented. If the host presents a new job during a final cycle, blocks stream back to back with no gap. A host that waits for the idle flag instead gets one idle cycle between jobs.

The result is formed combinationally from the last round and is not held in a register. It must be taken on the clock edge that ends the last cycle. A combinational flag reports a key with bad byte parity, but only while the opcode asks for a cipher job.

Top module: `des_iter_core`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released with the opcode at 00, idle_o is 1 and last_o is 0.
- R2: Opcode encoding: 00 and 11 are both "no operation", 01 is encrypt and 10 is decrypt. A no-operation sampled by the engine lasts one cycle and leaves idle_o at 1 in the following cycle.
- R3: An encrypt or decrypt job lasts exactly 16 cycles, starting at the edge that samples it. idle_o is 0 in all 16 cycles, and last_o is 1 only in the 16th. idle_o and last_o are never both 1.
- R4: In the last cycle of an encrypt job, dout_o holds the standard DES ciphertext of the captured block under the captured key.
- R5: In the last cycle of a decrypt job, dout_o holds the standard DES plaintext of the captured block under the captured key.
- R6: In cycles where both idle_o and last_o are 0, the value on op_i has no effect on the running job or on its timing.
- R7: key_i and din_i are captured only on the edge that starts a job. Changes to them during the job do not alter its result.
- R8: An encrypt or decrypt sampled while last_o is 1 starts the next job at that edge, so its first cycle directly follows the previous last cycle.
- R9: A host that presents a job only while idle_o is 1, with one no-operation after each job, sees exactly one idle cycle between the last cycle of one job and the first cycle of the next.
- R10: key_err_o is combinational. It is 1 exactly when op_i is 01 or 10 and at least one of the eight key bytes holds an even number of ones (odd parity per byte is expected). It is 0 whenever op_i is 00 or 11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| arst | input | 1 | Asynchronous reset, active high |
| op_i | input | 2 | Opcode: 00/11 none, 01 encrypt, 10 decrypt |
| key_i | input | 64 | Cipher key with one parity bit per byte |
| din_i | input | 64 | Input block |
| dout_o | output | 64 | Result, valid only while last_o is 1 |
| idle_o | output | 1 | Engine is idle |
| last_o | output | 1 | Final cycle of a cipher job |
| key_err_o | output | 1 | Key parity error while a cipher opcode is applied |

## Verification
The top carries no parameters. The cipher fixes every width, the round count and the rotation schedule, and the package holds them as constants. The bench therefore builds the engine with these fixed values. Because the sizes are fixed, published known-answer vectors apply directly, including the all-zero key, and each one is run in both directions. The bench streams jobs through the last-cycle flag and also separates jobs with a single no-operation. While a job runs, it scrambles the opcode, key and data inputs.

// File: rtl/des_pkg.sv
`timescale 1ns/1ps
package des_pkg;

    localparam int BLK_W     = 64;
    localparam int HALF_W    = BLK_W / 2;
    localparam int KEY_W     = 64;
    localparam int KEY_BYTES = KEY_W / 8;
    localparam int CD_W      = 56;
    localparam int CD_HALF   = CD_W / 2;
    localparam int SUBKEY_W  = 48;
    localparam int N_ROUNDS  = 16;
    localparam int CNT_W     = $clog2(N_ROUNDS);
    localparam int N_SBOX    = 8;
    localparam int SBOX_IN   = SUBKEY_W / N_SBOX;
    localparam int SBOX_OUT  = HALF_W / N_SBOX;

    typedef enum logic [1:0] {
        OP_NONE = 2'b00,
        OP_ENC  = 2'b01,
        OP_DEC  = 2'b10,
        OP_RSVD = 2'b11
    } op_e;

    typedef struct packed {
        logic                busy;
        logic                decrypt;
        logic [CNT_W-1:0]    step;
        logic [HALF_W-1:0]   left;
        logic [HALF_W-1:0]   right;
        logic [CD_W-1:0]     cd;
    } core_st_t;

    // Bit numbering in the tables: 1 is the most significant bit.
    localparam int IP_T [64] = '{
        58, 50, 42, 34, 26, 18, 10, 2,  60, 52, 44, 36, 28, 20, 12, 4,
        62, 54, 46, 38, 30, 22, 14, 6,  64, 56, 48, 40, 32, 24, 16, 8,
        57, 49, 41, 33, 25, 17,  9, 1,  59, 51, 43, 35, 27, 19, 11, 3,
        61, 53, 45, 37, 29, 21, 13, 5,  63, 55, 47, 39, 31, 23, 15, 7
    };

    localparam int PC1_T [56] = '{
        57, 49, 41, 33, 25, 17,  9,   1, 58, 50, 42, 34, 26, 18,
        10,  2, 59, 51, 43, 35, 27,  19, 11,  3, 60, 52, 44, 36,
        63, 55, 47, 39, 31, 23, 15,   7, 62, 54, 46, 38, 30, 22,
        14,  6, 61, 53, 45, 37, 29,  21, 13,  5, 28, 20, 12,  4
    };

    localparam int PC2_T [48] = '{
        14, 17, 11, 24,  1,  5,   3, 28, 15,  6, 21, 10,
        23, 19, 12,  4, 26,  8,  16,  7, 27, 20, 13,  2,
        41, 52, 31, 37, 47, 55,  30, 40, 51, 45, 33, 48,
        44, 49, 39, 56, 34, 53,  46, 42, 50, 36, 29, 32
    };

    localparam int P_T [32] = '{
        16,  7, 20, 21, 29, 12, 28, 17,   1, 15, 23, 26,  5, 18, 31, 10,
         2,  8, 24, 14, 32, 27,  3,  9,  19, 13, 30,  6, 22, 11,  4, 25
    };

    // One entry per box, 64 nibbles, index = row*16 + column, first entry in the top nibble.
    localparam logic [255:0] SBOX_T [8] = '{
        256'hE4D12FB83A6C5907_0F74E2D1A6CB9538_41E8D62BFC973A50_FC8249175B3EA06D,
        256'hF18E6B34972DC05A_3D47F28EC01A69B5_0E7BA4D158C6932F_D8A13F42B67C05E9,
        256'hA09E63F51DC7B428_D709346A285ECBF1_D6498F30B12C5AE7_1AD069874FE3B52C,
        256'h7DE3069A1285BC4F_D8B56F03472C1AE9_A690CB7DF13E5284_3F06A1D8945BC72E,
        256'h2C417AB6853FD0E9_EB2C47D150FA3986_421BAD78F9C5630E_B8C71E2D6F09A453,
        256'hC1AF92680D34E75B_AF427C9561DE0B38_9EF528C3704A1DB6_432C95FABE17608D,
        256'h4B2EF08D3C975A61_D0B7491AE35C2F86_14BDC37EAF680592_6BD814A7950FE23C,
        256'hD2846FB1A93E50C7_1FD8A374C56B0E92_7B419CE206ADF358_21E74A8DFC90356B
    };

    function automatic logic [BLK_W-1:0] init_perm(input logic [BLK_W-1:0] x);
        logic [BLK_W-1:0] y;
        y = '0;
        for (int i = 0; i < BLK_W; i++) y[BLK_W-1-i] = x[BLK_W-IP_T[i]];
        return y;
    endfunction

    function automatic logic [BLK_W-1:0] final_perm(input logic [BLK_W-1:0] x);
        logic [BLK_W-1:0] y;
        y = '0;
        for (int i = 0; i < BLK_W; i++) y[BLK_W-IP_T[i]] = x[BLK_W-1-i];
        return y;
    endfunction

    function automatic logic [CD_W-1:0] key_select(input logic [KEY_W-1:0] k);
        logic [CD_W-1:0] y;
        y = '0;
        for (int i = 0; i < CD_W; i++) y[CD_W-1-i] = k[KEY_W-PC1_T[i]];
        return y;
    endfunction

    function automatic logic [SUBKEY_W-1:0] key_compress(input logic [CD_W-1:0] cd);
        logic [SUBKEY_W-1:0] y;
        y = '0;
        for (int i = 0; i < SUBKEY_W; i++) y[SUBKEY_W-1-i] = cd[CD_W-PC2_T[i]];
        return y;
    endfunction

    function automatic logic [SUBKEY_W-1:0] expand(input logic [HALF_W-1:0] r);
        logic [SUBKEY_W-1:0] y;
        int src;
        y = '0;
        for (int i = 0; i < SUBKEY_W; i++) begin
            src = ((4 * (i / SBOX_IN) + (i % SBOX_IN) - 1 + HALF_W) % HALF_W) + 1;
            y[SUBKEY_W-1-i] = r[HALF_W-src];
        end
        return y;
    endfunction

    function automatic logic [HALF_W-1:0] straight_perm(input logic [HALF_W-1:0] x);
        logic [HALF_W-1:0] y;
        y = '0;
        for (int i = 0; i < HALF_W; i++) y[HALF_W-1-i] = x[HALF_W-P_T[i]];
        return y;
    endfunction

    function automatic logic [SBOX_OUT-1:0] sbox_lookup(input int n, input logic [SBOX_IN-1:0] b);
        logic [5:0] idx;
        idx = {b[5], b[0], b[4:1]};
        return SBOX_T[n][255 - 4 * int'(idx) -: 4];
    endfunction

    // Rotation applied before each round; decryption walks the schedule backwards.
    function automatic int rot_amount(input logic decrypt, input logic [CNT_W-1:0] step);
        logic single;
        single = (step == 4'd1) || (step == 4'd8) || (step == 4'd15);
        if (decrypt) return (step == 4'd0) ? 0 : (single ? 1 : 2);
        return (single || step == 4'd0) ? 1 : 2;
    endfunction

endpackage

// File: rtl/des_key_check.sv
`timescale 1ns/1ps
module des_key_check
    import des_pkg::*;
(
    input  logic [KEY_W-1:0] key_i,
    output logic             bad_o
);
    logic [KEY_BYTES-1:0] byte_bad;

    for (genvar b = 0; b < KEY_BYTES; b++) begin : g_byte
        assign byte_bad[b] = ~^key_i[8*b +: 8];
    end

    assign bad_o = |byte_bad;
endmodule

// File: rtl/des_keysched.sv
`timescale 1ns/1ps
module des_keysched
    import des_pkg::*;
(
    input  logic [CD_W-1:0]     cd_i,
    input  logic                decrypt_i,
    input  logic [CNT_W-1:0]    step_i,
    output logic [CD_W-1:0]     cd_o,
    output logic [SUBKEY_W-1:0] subkey_o
);
    logic [CD_HALF-1:0] c_in, d_in, c_out, d_out;
    int amt;

    assign c_in = cd_i[CD_W-1:CD_HALF];
    assign d_in = cd_i[CD_HALF-1:0];

    always_comb begin
        amt   = rot_amount(decrypt_i, step_i);
        c_out = c_in;
        d_out = d_in;
        if (decrypt_i) begin
            if (amt == 1) begin
                c_out = {c_in[0], c_in[CD_HALF-1:1]};
                d_out = {d_in[0], d_in[CD_HALF-1:1]};
            end else if (amt == 2) begin
                c_out = {c_in[1:0], c_in[CD_HALF-1:2]};
                d_out = {d_in[1:0], d_in[CD_HALF-1:2]};
            end
        end else begin
            if (amt == 1) begin
                c_out = {c_in[CD_HALF-2:0], c_in[CD_HALF-1]};
                d_out = {d_in[CD_HALF-2:0], d_in[CD_HALF-1]};
            end else if (amt == 2) begin
                c_out = {c_in[CD_HALF-3:0], c_in[CD_HALF-1:CD_HALF-2]};
                d_out = {d_in[CD_HALF-3:0], d_in[CD_HALF-1:CD_HALF-2]};
            end
        end
    end

    assign cd_o     = {c_out, d_out};
    assign subkey_o = key_compress(cd_o);
endmodule

// File: rtl/des_feistel.sv
`timescale 1ns/1ps
module des_feistel
    import des_pkg::*;
(
    input  logic [HALF_W-1:0]   r_i,
    input  logic [SUBKEY_W-1:0] subkey_i,
    output logic [HALF_W-1:0]   f_o
);
    logic [SUBKEY_W-1:0] mixed;
    logic [HALF_W-1:0]   s_out;

    assign mixed = expand(r_i) ^ subkey_i;

    for (genvar g = 0; g < N_SBOX; g++) begin : g_box
        assign s_out[HALF_W-1-SBOX_OUT*g -: SBOX_OUT] =
            sbox_lookup(g, mixed[SUBKEY_W-1-SBOX_IN*g -: SBOX_IN]);
    end

    assign f_o = straight_perm(s_out);
endmodule

// File: rtl/des_iter_core.sv
`timescale 1ns/1ps
module des_iter_core
    import des_pkg::*;
(
    input  logic             clk,
    input  logic             arst,
    input  logic [1:0]       op_i,
    input  logic [KEY_W-1:0] key_i,
    input  logic [BLK_W-1:0] din_i,
    output logic [BLK_W-1:0] dout_o,
    output logic             idle_o,
    output logic             last_o,
    output logic             key_err_o
);
    core_st_t st_d, st_q;

    logic                is_last, can_take, op_start, key_bad;
    logic [CD_W-1:0]     cd_next;
    logic [SUBKEY_W-1:0] subkey;
    logic [HALF_W-1:0]   f_val, l_new, r_new;

    des_keysched i_keysched (
        .cd_i      (st_q.cd),
        .decrypt_i (st_q.decrypt),
        .step_i    (st_q.step),
        .cd_o      (cd_next),
        .subkey_o  (subkey)
    );

    des_feistel i_feistel (
        .r_i      (st_q.right),
        .subkey_i (subkey),
        .f_o      (f_val)
    );

    des_key_check i_key_check (
        .key_i (key_i),
        .bad_o (key_bad)
    );

    assign op_start = (op_i == OP_ENC) || (op_i == OP_DEC);
    assign is_last  = st_q.busy && (st_q.step == CNT_W'(N_ROUNDS - 1));
    assign can_take = !st_q.busy || is_last;
    assign l_new    = st_q.right;
    assign r_new    = st_q.left ^ f_val;

    always_comb begin
        st_d = st_q;
        if (can_take) begin
            st_d.step = '0;
            if (op_start) begin
                st_d.busy    = 1'b1;
                st_d.decrypt = (op_i == OP_DEC);
                {st_d.left, st_d.right} = init_perm(din_i);
                st_d.cd      = key_select(key_i);
            end else begin
                st_d.busy = 1'b0;
            end
        end else begin
            st_d.step  = st_q.step + 1'b1;
            st_d.left  = l_new;
            st_d.right = r_new;
            st_d.cd    = cd_next;
        end
    end

    always_ff @(posedge clk or posedge arst) begin
        if (arst) st_q <= '0;
        else      st_q <= st_d;
    end

    assign dout_o    = final_perm({r_new, l_new});
    assign idle_o    = !st_q.busy;
    assign last_o    = is_last;
    assign key_err_o = op_start && key_bad;

    // R3
    busy_hold_chk: assert property (@(posedge clk) disable iff (arst)
        (!idle_o && !last_o) |=> !idle_o);

    // R3
    step_adv_chk: assert property (@(posedge clk) disable iff (arst)
        (!idle_o && !last_o) |=> (st_q.step == $past(st_q.step) + 1'b1));

    // R3
    last_single_chk: assert property (@(posedge clk) disable iff (arst)
        last_o |=> !last_o);

    // R8
    stream_start_chk: assert property (@(posedge clk) disable iff (arst)
        (last_o && op_start) |=> (!idle_o && st_q.step == '0));

    // R2
    nop_idle_chk: assert property (@(posedge clk) disable iff (arst)
        ((idle_o || last_o) && !op_start) |=> idle_o);

    // R10
    always_comb begin
        key_err_gate_chk: assert (op_start || !key_err_o);
    end
endmodule

// File: tb/test_des_iter_core.sv
`timescale 1ns/1ps
module test_des_iter_core;
    import des_pkg::*;

    logic        clk = 1'b0;
    logic        arst = 1'b1;
    logic [1:0]  op_i = 2'b00;
    logic [63:0] key_i = '0;
    logic [63:0] din_i = '0;
    logic [63:0] dout_o;
    logic        idle_o, last_o, key_err_o;

    int cyc = 0;
    int n_checks = 0;
    int n_err = 0;

    typedef struct {
        logic [63:0] data;
        int          due;
        string       tag;
    } exp_t;
    exp_t sb_q[$];

    localparam logic [63:0] K1 = 64'h133457799BBCDFF1;
    localparam logic [63:0] P1 = 64'h0123456789ABCDEF;
    localparam logic [63:0] C1 = 64'h85E813540F0AB405;
    localparam logic [63:0] K2 = 64'h0E329232EA6D0D73;
    localparam logic [63:0] P2 = 64'h8787878787878787;
    localparam logic [63:0] C2 = 64'h0000000000000000;
    localparam logic [63:0] CZ = 64'h8CA64DE9C1B123A7;

    des_iter_core i_des_iter_core (
        .clk       (clk),
        .arst      (arst),
        .op_i      (op_i),
        .key_i     (key_i),
        .din_i     (din_i),
        .dout_o    (dout_o),
        .idle_o    (idle_o),
        .last_o    (last_o),
        .key_err_o (key_err_o)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", what, act, exp);
        end
    endtask

    // R6 R7: while a job runs, opcode, key and data are scrambled
    task automatic wait_ready();
        while (!(idle_o || last_o)) begin
            op_i  = 2'((cyc % 3) + 1);
            key_i = ~key_i;
            din_i = din_i ^ 64'hA5A5_5A5A_C3C3_3C3C;
            @(negedge clk);
        end
    endtask

    task automatic issue(input logic [1:0] op, input logic [63:0] key, input logic [63:0] din,
                         input logic [63:0] exp, input string tag, output int t);
        wait_ready();
        t = cyc;
        op_i  = op;
        key_i = key;
        din_i = din;
        sb_q.push_back('{data: exp, due: cyc + N_ROUNDS, tag: tag});
        @(negedge clk);
    endtask

    task automatic idle_op(input logic [1:0] code, output int t);
        wait_ready();
        t = cyc;
        op_i = code;
        @(negedge clk);
        check(idle_o == 1'b1, "R2 idle after no-op", 64'(idle_o), 64'd1);
        check(last_o == 1'b0, "R2 no last flag after no-op", 64'(last_o), 64'd0);
    endtask

    // Scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (!arst) begin
                if (idle_o && last_o)
                    check(1'b0, "R3 idle and last both high", 64'd1, 64'd0);
                if (last_o) begin
                    if (sb_q.size() == 0) begin
                        check(1'b0, "R3 unexpected last cycle", 64'(cyc), 64'd0);
                    end else begin
                        exp_t e;
                        e = sb_q.pop_front();
                        check(dout_o == e.data, e.tag, dout_o, e.data);
                        check(cyc == e.due, {"R3 job length, ", e.tag}, 64'(cyc), 64'(e.due));
                    end
                end
            end
        end
    end

    initial begin
        #200000;
        n_err++;
        $display("FAIL R3 watchdog: actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        int t0, t1, t2, tn, t3, t4, t5, tz;
        repeat (3) @(negedge clk);
        #1;
        check(idle_o == 1'b1, "R1 idle in reset", 64'(idle_o), 64'd1);
        check(last_o == 1'b0, "R1 last low in reset", 64'(last_o), 64'd0);
        arst = 1'b0;
        @(negedge clk);
        #1;
        check(idle_o == 1'b1, "R1 idle after reset", 64'(idle_o), 64'd1);
        check(last_o == 1'b0, "R1 last low after reset", 64'(last_o), 64'd0);

        // R10: parity flag, all within one low clock phase
        @(negedge clk);
        key_i = 64'h0; op_i = 2'b01; #0.3;
        check(key_err_o == 1'b1, "R10 zero key with encrypt", 64'(key_err_o), 64'd1);
        op_i = 2'b00; #0.3;
        check(key_err_o == 1'b0, "R10 zero key with no-op 00", 64'(key_err_o), 64'd0);
        op_i = 2'b11; #0.3;
        check(key_err_o == 1'b0, "R10 zero key with no-op 11", 64'(key_err_o), 64'd0);
        op_i = 2'b10; #0.3;
        check(key_err_o == 1'b1, "R10 zero key with decrypt", 64'(key_err_o), 64'd1);
        key_i = K1; #0.3;
        check(key_err_o == 1'b0, "R10 good key with decrypt", 64'(key_err_o), 64'd0);
        key_i = K1 ^ 64'h0000_0100_0000_0000; #0.3;
        check(key_err_o == 1'b1, "R10 one flipped bit", 64'(key_err_o), 64'd1);
        op_i = 2'b00;
        @(negedge clk);

        // R2: code 11 behaves as no-op
        idle_op(2'b11, tz);

        // R8: streamed jobs
        issue(2'b01, K1, P1, C1, "R4 R6 R7 encrypt vector one", t0);
        issue(2'b10, K1, C1, P1, "R5 R6 R7 decrypt vector one", t1);
        check(t1 == t0 + N_ROUNDS, "R8 streamed start", 64'(t1 - t0), 64'(N_ROUNDS));
        issue(2'b01, K2, P2, C2, "R4 encrypt vector two", t2);
        check(t2 == t1 + N_ROUNDS, "R8 second streamed start", 64'(t2 - t1), 64'(N_ROUNDS));

        // R9: block mode with one no-op
        idle_op(2'b00, tn);
        check(tn == t2 + N_ROUNDS, "R9 no-op taken at last cycle", 64'(tn - t2), 64'(N_ROUNDS));
        issue(2'b10, K2, C2, P2, "R5 decrypt vector two", t3);
        check(t3 == tn + 1, "R9 single idle gap", 64'(t3 - tn), 64'd1);

        idle_op(2'b00, tn);
        issue(2'b01, 64'h0, 64'h0, CZ, "R4 zero key encrypt", t4);
        issue(2'b10, 64'h0, CZ, 64'h0, "R5 zero key decrypt", t5);
        check(t5 == t4 + N_ROUNDS, "R8 zero key stream", 64'(t5 - t4), 64'(N_ROUNDS));
        idle_op(2'b00, tn);

        repeat (20) @(negedge clk);
        check(sb_q.size() == 0, "R3 all jobs completed", 64'(sb_q.size()), 64'd0);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule